// File: doc/BRIEF.md
# UART Transmit-Empty Interrupt Generator

This block raises the transmitter-holding-empty interrupt of a UART that has a transmit FIFO. It watches the FIFO fill count. When the FIFO drains to zero, it raises an interrupt line and presents identification code 2. When no transmit interrupt is pending, the code is 1.

Software clears the interrupt in one of two ways. It can write the holding register, loading anywhere from one to sixteen characters. It can also read the identification register.

A FIFO that has never held two characters at once since it last ran dry keeps the interrupt back for a while. The wait is one character time without its final stop bit, and it is counted in baud-rate ticks at sixteen per bit. The first interrupt after reset, or after a change of FIFO mode, skips this wait.

Top module: `uart_txe_irq`

## Requirements
- R1: After reset, `irq` is 0 and `iir_code` is 1 (4'b0001).
- R2: `irq` can only be asserted while both `fifo_en` and `txe_ie` are 1. Dropping either one clears a pending interrupt on the next cycle.
- R3: Suppose `tx_count` reached 2 or more since the FIFO was last empty. When `tx_count` is then 0, `irq` rises on the following clock, and `iir_code` reads 2 (4'b0010) while `irq` is high.
- R4: Suppose `tx_count` stayed below 2 since the FIFO was last empty. When the FIFO empties, `irq` rises exactly LIM+1 clocks after the first cycle with `tx_count` 0, where `baud_en` is high on every cycle. LIM = 16*(6 + `word_len` + `par_en` + `two_stop`).
- R5: The hold-off of R4 advances only on cycles where `baud_en` is 1.
- R6: A `thr_wr` pulse while `irq` is high clears it on the next clock, and `iir_code` returns to 1.
- R7: An `iir_rd` pulse while `irq` is high clears it on the next clock. No interrupt follows while the FIFO stays empty. After the FIFO goes non-empty and then empty again, the interrupt recurs.
- R8: If the FIFO becomes non-empty before the hold-off ends, no interrupt is raised. The next drain starts a full new hold-off.
- R9: The first interrupt after a `mode_chg` pulse (or after reset) is raised without the hold-off.
- R10: Two events can land in the same cycle. A `thr_wr` in the cycle the hold-off ends suppresses the interrupt. An `iir_rd` in the cycle the interrupt is being raised does not suppress it.
- R11: `word_len` values 0..3 select 5..8 data bits. `par_en` adds one bit to the hold-off and `two_stop` adds one bit; the start bit is always counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enabled |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| mode_chg | input | 1 | Pulse: FIFO mode setting changed |
| tx_count | input | CNT_W | Transmit FIFO fill level |
| thr_wr | input | 1 | Pulse: holding register write |
| iir_rd | input | 1 | Pulse: identification register read |
| baud_en | input | 1 | Baud tick, OVS per bit |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Second stop bit present |
| irq | output | 1 | Transmit-empty interrupt |
| iir_code | output | 4 | 2 when pending, 1 otherwise |

## Verification
There are two same-cycle collisions. The first is the hold-off timer reaching its limit while the holding register is being written. The second is the interrupt being raised while the identification register is read.

The bench provokes the first by counting exactly LIM cycles after the drain and then pulsing `thr_wr` in that cycle. It expects `irq` to stay low, and it expects a later full hold-off to end in an interrupt.

It provokes the second by draining a FIFO that held two characters, and it pulses `iir_rd` in the same cycle that `tx_count` reaches 0. It expects `irq` to be high on the next clock.

// File: rtl/uart_txe_irq.sv
module uart_txe_irq #(
  parameter int CNT_W = 5,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             txe_ie,
  input  logic             mode_chg,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             baud_en,
  input  logic [1:0]       word_len,
  input  logic             par_en,
  input  logic             two_stop,
  output logic             irq,
  output logic [3:0]       iir_code
);
  localparam int TW = $clog2(OVS * 12 + 1);

  logic          pend, armed, first, seen2, was_empty;
  logic [TW-1:0] tcnt;

  wire en    = fifo_en & txe_ie;
  wire empty = (tx_count == '0);
  wire [3:0] nbits = 4'd6 + {2'b00, word_len} + {3'b000, par_en} + {3'b000, two_stop};
  wire [TW-1:0] lim = TW'(nbits) * TW'(OVS);

  wire imm   = seen2 | first;
  wire ready = en & empty & armed & ~pend & ~thr_wr;
  wire fire  = ready & (imm | (tcnt == lim));
  wire trun  = ready & ~imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      armed     <= 1'b1;
      first     <= 1'b1;
      seen2     <= 1'b0;
      was_empty <= 1'b1;
      tcnt      <= '0;
    end else begin
      pend      <= fire | (pend & ~(thr_wr | iir_rd | ~en));
      was_empty <= empty;

      if (fire)                     armed <= 1'b0;
      else if (!empty || mode_chg)  armed <= 1'b1;

      if (mode_chg)  first <= 1'b1;
      else if (fire) first <= 1'b0;

      if (tx_count >= CNT_W'(2))     seen2 <= 1'b1;
      else if (was_empty && !empty)  seen2 <= 1'b0;

      if (!trun)                         tcnt <= '0;
      else if (baud_en && tcnt != lim)   tcnt <= tcnt + 1'b1;
    end
  end

  assign irq      = pend;
  assign iir_code = pend ? 4'h2 : 4'h1;
endmodule

// File: rtl/uart_txe_irq_chk.sv
module uart_txe_irq_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             txe_ie,
  input logic [CNT_W-1:0] tx_count,
  input logic             thr_wr,
  input logic             iir_rd,
  input logic             irq,
  input logic [3:0]       iir_code
);
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !(fifo_en && txe_ie) |=> !irq); // R2
  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(fifo_en && txe_ie)); // R2
  AST_RISE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(tx_count) == '0); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) irq && thr_wr |=> !irq); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) irq && iir_rd |=> !irq); // R7
  AST_CODE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> iir_code == 4'h2); // R3
endmodule

bind uart_txe_irq uart_txe_irq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_uart_txe_irq.sv
module tb_uart_txe_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, txe_ie = 1'b0, mode_chg = 1'b0;
  logic [4:0] tx_count = '0;
  logic       thr_wr = 1'b0, iir_rd = 1'b0;
  logic       baud_en = 1'b1, gate = 1'b0;
  logic [1:0] word_len = 2'd0;
  logic       par_en = 1'b0, two_stop = 1'b0;
  logic       irq;
  logic [3:0] iir_code;

  int cyc = 0, n_chk = 0, n_bad = 0;

  typedef struct { int due; logic v; string req; } exp_t;
  exp_t q[$];

  uart_txe_irq #(.CNT_W(5), .OVS(16)) dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) baud_en <= gate ? ~baud_en : 1'b1;

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [3:0] ec;
        ec = q[i].v ? 4'h2 : 4'h1;
        n_chk++;
        if (irq !== q[i].v || iir_code !== ec) begin
          n_bad++;
          $display("FAIL %s cyc %0d: irq=%b code=%0d expected irq=%b code=%0d",
                   q[i].req, cyc, irq, iir_code, q[i].v, ec);
        end
        q.delete(i);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_irq(int d, logic v, string r);
    q.push_back('{cyc + d, v, r});
  endtask

  task automatic refill_one;
    thr_wr = 1'b1; tx_count = 5'd1; step();
    thr_wr = 1'b0; step();
  endtask

  task automatic drain_burst;
    thr_wr = 1'b1; tx_count = 5'd1; step();
    tx_count = 5'd2; step();
    thr_wr = 1'b0; tx_count = 5'd1; step();
    tx_count = 5'd0;
  endtask

  task automatic delayed_run(int lim, string r);
    refill_one();
    tx_count = 5'd0;
    expect_irq(lim, 1'b0, r);
    expect_irq(lim + 1, 1'b1, r);
    step(lim + 3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_irq(0, 1'b0, "R1");
    step();
    // R2: disabled while empty and armed
    for (int k = 1; k <= 4; k++) expect_irq(k, 1'b0, "R2");
    step(5);
    txe_ie = 1'b1;
    expect_irq(1, 1'b1, "R2");
    step(2);
    // R6: write clears
    thr_wr = 1'b1; tx_count = 5'd1;
    expect_irq(1, 1'b0, "R6");
    step(); thr_wr = 1'b0; step();
    // R4: delayed drain, 5 data bits, 96 ticks
    tx_count = 5'd0;
    expect_irq(96, 1'b0, "R4");
    expect_irq(97, 1'b1, "R4");
    step(100);
    // R7: read clears, no refire while empty, recurs after refill
    iir_rd = 1'b1;
    expect_irq(1, 1'b0, "R7");
    step(); iir_rd = 1'b0;
    expect_irq(20, 1'b0, "R7");
    step(21);
    delayed_run(96, "R7");
    // R3: two bytes held -> immediate
    refill_one();
    drain_burst();
    expect_irq(1, 1'b1, "R3");
    step(3);
    // R8: refill aborts hold-off
    refill_one();
    tx_count = 5'd0;
    expect_irq(97, 1'b0, "R8");
    step(50);
    thr_wr = 1'b1; tx_count = 5'd1; step();
    thr_wr = 1'b0; step();
    tx_count = 5'd0;
    expect_irq(96, 1'b0, "R8");
    expect_irq(97, 1'b1, "R8");
    step(100);
    // R5: baud tick every other cycle, ~192 cycles
    refill_one();
    gate = 1'b1;
    tx_count = 5'd0;
    expect_irq(180, 1'b0, "R5");
    expect_irq(200, 1'b1, "R5");
    step(205);
    gate = 1'b0; step(2);
    // R11: frame variants
    word_len = 2'd3; par_en = 1'b1; two_stop = 1'b1;
    delayed_run(176, "R11");
    word_len = 2'd2; par_en = 1'b1; two_stop = 1'b0;
    delayed_run(144, "R11");
    word_len = 2'd0; par_en = 1'b0; two_stop = 1'b0;
    // R9: mode change bypasses hold-off
    refill_one();
    mode_chg = 1'b1; step(); mode_chg = 1'b0;
    tx_count = 5'd0;
    expect_irq(1, 1'b1, "R9");
    step(3);
    // R10: write in the expiry cycle
    refill_one();
    tx_count = 5'd0;
    step(96);
    thr_wr = 1'b1;
    expect_irq(1, 1'b0, "R10");
    step(); thr_wr = 1'b0; tx_count = 5'd1; step();
    tx_count = 5'd0;
    expect_irq(96, 1'b0, "R10");
    expect_irq(97, 1'b1, "R10");
    step(100);
    // R10: read in the raising cycle
    refill_one();
    drain_burst();
    iir_rd = 1'b1;
    expect_irq(1, 1'b1, "R10");
    step(); iir_rd = 1'b0; step(2);
    // R2: disable clears, re-enable while empty stays quiet
    txe_ie = 1'b0;
    expect_irq(1, 1'b0, "R2");
    step(); txe_ie = 1'b1;
    expect_irq(3, 1'b0, "R2");
    step(5);
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule